// File: doc/BRIEF.md
# Tagged Converter Sample Readout Queue

This block sits between two dual-channel converter front ends and a host register port. The two converters run side by side, so every conversion step delivers one 12-bit sample from each chip in the same cycle. Two steps make a group: the first step carries channel A of both chips and the second carries channel B. Once a group is complete, the block writes four entries into a queue. Each entry carries the sample, the chip it came from, the number of its group and its channel index within the group.

The host learns the channel of the entry at the head of the queue from a status register at offset 0x08. It then reads the data register at offset 0x0A. That read returns the tagged word and removes the entry from the queue, so the status register must be read first. Sample bits are passed through unchanged. Converter output is two's complement whatever input range is selected, and the block keeps it in that form.

The capture sequencer is a three-state machine. CAP_WAIT_A holds both samples of a step and moves to CAP_WAIT_B (transition "first half"). CAP_WAIT_B holds the second step. If there are at least four free entries it moves to CAP_PUSH (transition "accept"). Otherwise it returns to CAP_WAIT_A and discards the group (transition "drop"). CAP_PUSH writes one entry per cycle for four cycles and then returns to CAP_WAIT_A (transition "group done"). A step that arrives while the machine is in CAP_PUSH is not captured.

Top module: `adc_tag_fifo`

## Requirements
- R1: After reset the queue is empty, the status register reads 0x0000, the sticky overflow flag is clear and the group counter is 0.
- R2: A complete group places four entries in the queue, in this order: chip 0 channel A, chip 1 channel A, chip 0 channel B, chip 1 channel B. The last entry is written on the fourth clock edge after the edge that captures the second step.
- R3: A data word holds the chip number in bit 15 (0 or 1), the group number in bits 14:12 and the 12-bit sample in bits 11:0. The sample is copied bit for bit, so negative two's complement codes keep their sign bit.
- R4: The 3-bit group number starts at 0, advances by one after every group that is stored, and wraps from 7 to 0.
- R5: Reading offset 0x08 returns the status word. Bit 0 is set when the queue is not empty. Bits 5:1 hold the channel of the head entry, equal to 2*chip + (0 for A, 1 for B), and read 0 when the queue is empty. Bit 6 is the overflow flag. All other bits read 0.
- R6: Reading offset 0x0A returns the head entry's data word and removes that entry, so the next status read describes the following entry.
- R7: Reading offset 0x0A while the queue is empty returns 0x0000 and leaves the queue unchanged.
- R8: If fewer than four entries are free when a group completes, the whole group is discarded and the overflow flag (status bit 6) is set. The entries already queued and the group counter stay unchanged.
- R9: Writing offset 0x08 with bit 6 set clears the overflow flag. A write with bit 6 clear leaves the flag as it is.
- R10: A read of any offset other than 0x08 or 0x0A returns 0x0000 and removes no entry.
- R11: Read data appears on reg_rdata on the clock edge that samples the read strobe, and it holds there until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | One conversion step is present on both sample inputs |
| chip0_sample | input | 12 | Sample from converter chip 0 (two's complement) |
| chip1_sample | input | 12 | Sample from converter chip 1 (two's complement) |
| reg_addr | input | 4 | Host register offset |
| reg_rd | input | 1 | Host read strobe, one cycle |
| reg_wr | input | 1 | Host write strobe, one cycle |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered host read data |

## Verification
The assertions check four things on every cycle: the entry count never passes the queue depth, nothing is written into a full queue and nothing is removed from an empty one, the group counter advances by one exactly when a group's fourth entry is written, and the overflow flag is set after a drop and stays set until it is cleared. An empty data read returning zero is also checked as it happens. Only the bench scenarios can show the write order inside a group, the tag fields and channel numbers seen from the host, the wrap of the group number over nine groups, and the fact that a dropped group leaves earlier entries intact. The same holds for pop-on-read against status reads and unmapped offsets.

// File: rtl/adc_tag_pkg.sv
package adc_tag_pkg;

    localparam int SAMPLE_W   = 12;
    localparam int BLK_W      = 3;
    localparam int WORD_W     = 16;
    localparam int GROUP_SIZE = 4;

    // host offsets, low four address bits
    localparam logic [3:0] OFS_STATUS = 4'h8;
    localparam logic [3:0] OFS_DATA   = 4'hA;

    // status word layout
    localparam int ST_NE_BIT  = 0;
    localparam int ST_CH_LSB  = 1;
    localparam int ST_CH_W    = 5;
    localparam int ST_OVF_BIT = 6;

    // data word layout
    localparam int WD_CHIP_BIT = 15;
    localparam int WD_BLK_LSB  = 12;

    typedef enum logic [1:0] {
        CAP_WAIT_A = 2'd0,
        CAP_WAIT_B = 2'd1,
        CAP_PUSH   = 2'd2
    } cap_state_t;

    typedef struct packed {
        logic              sub;   // 0: channel A, 1: channel B
        logic [WORD_W-1:0] word;  // {chip, group, sample}
    } q_entry_t;

endpackage

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
    import adc_tag_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_valid,
    input  logic [SAMPLE_W-1:0] chip0_sample,
    input  logic [SAMPLE_W-1:0] chip1_sample,
    input  logic [CNT_W-1:0]    q_count,
    output logic                push,
    output q_entry_t            push_entry,
    output logic                drop
);

    localparam int IDX_W = $clog2(GROUP_SIZE);
    localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(DEPTH - GROUP_SIZE);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(GROUP_SIZE - 1);

    cap_state_t          state_q, state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [BLK_W-1:0]    blk_q;
    logic [SAMPLE_W-1:0] stage_q [GROUP_SIZE];
    logic                room;

    assign room = (q_count <= ROOM_LIMIT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_WAIT_A;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_WAIT_A: if (step_valid) state_d = CAP_WAIT_B;
            CAP_WAIT_B: if (step_valid) state_d = room ? CAP_PUSH : CAP_WAIT_A;
            CAP_PUSH:   if (idx_q == LAST_IDX) state_d = CAP_WAIT_A;
            default:    state_d = CAP_WAIT_A;
        endcase
    end

    // staging: slot 2*k holds chip 0 of step k, slot 2*k+1 holds chip 1
    genvar gs;
    generate
        for (gs = 0; gs < GROUP_SIZE; gs++) begin : g_stage
            localparam bit IS_B    = (gs >= GROUP_SIZE / 2);
            localparam bit IS_CHIP1 = (gs % 2) == 1;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[gs] <= '0;
                end else if (step_valid &&
                             (state_q == (IS_B ? CAP_WAIT_B : CAP_WAIT_A))) begin
                    stage_q[gs] <= IS_CHIP1 ? chip1_sample : chip0_sample;
                end
            end
        end
    endgenerate

    // write index and group counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            blk_q <= '0;
        end else begin
            unique case (state_q)
                CAP_WAIT_A: idx_q <= '0;
                CAP_WAIT_B: idx_q <= '0;
                CAP_PUSH: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) blk_q <= blk_q + 1'b1;
                end
                default: idx_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        push       = 1'b0;
        drop       = 1'b0;
        push_entry = '0;
        unique case (state_q)
            CAP_WAIT_A: ;
            CAP_WAIT_B: drop = step_valid && !room;
            CAP_PUSH: begin
                push                  = 1'b1;
                push_entry.sub        = idx_q[1];
                push_entry.word       = {idx_q[0], blk_q, stage_q[idx_q]};
            end
            default: ;
        endcase
    end

    // R4
    blk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_PUSH && idx_q == LAST_IDX) |=> (blk_q == $past(blk_q) + 1'b1));

    // R8
    drop_keeps_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (blk_q == $past(blk_q) && state_q == CAP_WAIT_A));

endmodule

// File: rtl/adc_tag_store.sv
module adc_tag_store
    import adc_tag_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  q_entry_t         push_entry,
    input  logic             pop,
    output q_entry_t         head,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    q_entry_t         mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            unique case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_ptr_q] <= push_entry;
    end

    assign head  = mem_q[rd_ptr_q];
    assign empty = (count_q == '0);
    assign count = count_q;

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count_q < CNT_W'(DEPTH)));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/adc_host_regs.sv
module adc_host_regs
    import adc_tag_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              clr_bit,
    input  q_entry_t          head,
    input  logic              empty,
    input  logic              drop,
    output logic              pop,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);

    logic              ovf_q;
    logic              clr_req;
    logic [WORD_W-1:0] status_w;
    logic [WORD_W-1:0] rdata_q;

    assign clr_req = reg_wr && (reg_addr == A_STATUS) && clr_bit;
    assign pop     = reg_rd && (reg_addr == A_DATA) && !empty;

    always_comb begin
        status_w                         = '0;
        status_w[ST_NE_BIT]              = !empty;
        status_w[ST_CH_LSB +: ST_CH_W]   = empty ? '0
                                         : ST_CH_W'({head.word[WD_CHIP_BIT], head.sub});
        status_w[ST_OVF_BIT]             = ovf_q;
    end

    // sticky overflow: a new drop wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (drop) begin
            ovf_q <= 1'b1;
        end else if (clr_req) begin
            ovf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            if (reg_addr == A_STATUS)    rdata_q <= status_w;
            else if (reg_addr == A_DATA) rdata_q <= empty ? '0 : head.word;
            else                         rdata_q <= '0;
        end
    end

    assign rdata = rdata_q;

    // R7
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_DATA && empty) |=> (rdata == '0));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf_q);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_req) |=> ovf_q);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(rdata));

endmodule

// File: rtl/adc_tag_fifo.sv
module adc_tag_fifo
    import adc_tag_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_valid,
    input  logic [SAMPLE_W-1:0] chip0_sample,
    input  logic [SAMPLE_W-1:0] chip1_sample,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_rd,
    input  logic                reg_wr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push, pop, drop, empty;
    q_entry_t         push_entry, head;
    logic [CNT_W-1:0] count;

    adc_capture_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_valid   (step_valid),
        .chip0_sample (chip0_sample),
        .chip1_sample (chip1_sample),
        .q_count      (count),
        .push         (push),
        .push_entry   (push_entry),
        .drop         (drop)
    );

    adc_tag_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .empty      (empty),
        .count      (count)
    );

    adc_host_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .clr_bit  (reg_wdata[ST_OVF_BIT]),
        .head     (head),
        .empty    (empty),
        .drop     (drop),
        .pop      (pop),
        .rdata    (reg_rdata)
    );

    // R2
    group_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !$past(push)) |-> (count <= CNT_W'(DEPTH - GROUP_SIZE)));

endmodule

// File: tb/adc_tag_fifo_tb.sv
module adc_tag_fifo_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_valid = 1'b0;
    logic [11:0] chip0_sample = '0;
    logic [11:0] chip1_sample = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int tests = 0;
    int fails = 0;

    // model: {channel[1:0], word[15:0]}
    logic [17:0] exp_q [$];
    logic [2:0]  exp_blk = '0;
    logic        exp_ovf = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_tag_fifo #(.DEPTH(DEPTH), .ADDR_W(4)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_valid   (step_valid),
        .chip0_sample (chip0_sample),
        .chip1_sample (chip1_sample),
        .reg_addr     (reg_addr),
        .reg_rd       (reg_rd),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_read(input logic [3:0] addr, output logic [15:0] val);
        @(negedge clk);
        reg_addr = addr;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        val      = reg_rdata;   // R11: registered on the sampling edge
    endtask

    task automatic host_write(input logic [3:0] addr, input logic [15:0] val);
        @(negedge clk);
        reg_addr  = addr;
        reg_wdata = val;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    function automatic logic [15:0] exp_status();
        logic [15:0] s = '0;
        s[0] = (exp_q.size() != 0);
        if (exp_q.size() != 0) s[2:1] = exp_q[0][17:16];
        s[6] = exp_ovf;
        return s;
    endfunction

    task automatic send_group(input logic [11:0] a0, input logic [11:0] a1,
                              input logic [11:0] b0, input logic [11:0] b1);
        @(negedge clk);
        step_valid = 1'b1; chip0_sample = a0; chip1_sample = a1;
        @(negedge clk);
        step_valid = 1'b0;
        @(negedge clk);
        step_valid = 1'b1; chip0_sample = b0; chip1_sample = b1;
        @(negedge clk);
        step_valid = 1'b0;
        repeat (6) @(negedge clk);
        if (exp_q.size() > DEPTH - 4) begin
            exp_ovf = 1'b1;
        end else begin
            exp_q.push_back({2'b00, 1'b0, exp_blk, a0});
            exp_q.push_back({2'b10, 1'b1, exp_blk, a1});
            exp_q.push_back({2'b01, 1'b0, exp_blk, b0});
            exp_q.push_back({2'b11, 1'b1, exp_blk, b1});
            exp_blk = exp_blk + 1'b1;
        end
    endtask

    // status then data for the head entry
    task automatic read_entry(input string req);
        logic [15:0] v;
        logic [15:0] e;
        host_read(4'h8, v);
        check({req, " R5 status"}, v, exp_status());
        e = (exp_q.size() != 0) ? exp_q[0][15:0] : 16'h0000;
        host_read(4'hA, v);
        check({req, " R6 data"}, v, e);
        if (exp_q.size() != 0) void'(exp_q.pop_front());
    endtask

    task automatic drain(input string req);
        while (exp_q.size() != 0) read_entry(req);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        host_read(4'h8, v);
        check("R1 reset status", v, 16'h0000);
        host_read(4'hA, v);
        check("R1 reset data empty", v, 16'h0000);
    endtask

    task automatic t_order();
        send_group(12'h123, 12'h456, 12'h789, 12'h0AB);
        // R2 order and R3 format come from the model entries
        drain("R2 R3 order");
        t_empty_status("R6 drained");
    endtask

    task automatic t_empty_status(input string req);
        logic [15:0] v;
        host_read(4'h8, v);
        check({req, " R5 empty status"}, v, exp_status());
    endtask

    task automatic t_negative();
        send_group(12'h800, 12'hFFF, 12'h7FF, 12'hF00);
        drain("R3 signed samples");
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        for (int g = 0; g < 9; g++) begin
            send_group(12'(g), 12'(g + 16), 12'(g + 32), 12'(g + 48));
            drain("R4 wrap");
        end
        // group number after nine more groups: (2 + 9) mod 8 = 3
        send_group(12'h001, 12'h002, 12'h003, 12'h004);
        host_read(4'hA, v);
        check("R4 wrapped group field", {13'b0, v[14:12]}, 16'd3);
        void'(exp_q.pop_front());
        drain("R4 tail");
    endtask

    task automatic t_empty_read();
        logic [15:0] v;
        host_read(4'hA, v);
        check("R7 empty data read", v, 16'h0000);
        send_group(12'h111, 12'h222, 12'h333, 12'h444);
        host_read(4'h8, v);
        check("R7 no pop on empty", v, exp_status());
        drain("R7 after");
    endtask

    task automatic t_other_addr();
        logic [15:0] v;
        send_group(12'h5A5, 12'hA5A, 12'h0F0, 12'hF0F);
        host_read(4'h0, v);
        check("R10 unmapped read zero", v, 16'h0000);
        host_read(4'hC, v);
        check("R10 unmapped read zero", v, 16'h0000);
        read_entry("R10 head kept");
        drain("R10 rest");
    endtask

    task automatic t_overflow();
        logic [15:0] v;
        send_group(12'h010, 12'h020, 12'h030, 12'h040);
        send_group(12'h050, 12'h060, 12'h070, 12'h080);
        send_group(12'hDEA, 12'hDEB, 12'hDEC, 12'hDED);  // dropped
        host_read(4'h8, v);
        check("R8 overflow flag", {9'b0, v[6:0]}, 16'h0041);
        drain("R8 kept entries");
        // next stored group carries the group number after the last kept one
        send_group(12'h0AA, 12'h0BB, 12'h0CC, 12'h0DD);
        host_read(4'hA, v);
        check("R8 group number not advanced", v, exp_q[0][15:0]);
        void'(exp_q.pop_front());
        drain("R8 tail");
    endtask

    task automatic t_clear();
        logic [15:0] v;
        host_write(4'h8, 16'hFFBF);
        host_read(4'h8, v);
        check("R9 write zero keeps flag", v, 16'h0040);
        host_write(4'h8, 16'h0040);
        exp_ovf = 1'b0;
        host_read(4'h8, v);
        check("R9 write one clears flag", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_negative();
        t_wrap();
        t_empty_read();
        t_other_addr();
        t_overflow();
        t_clear();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule